// File: doc/BRIEF.md
# Crosspoint Routing Control Bank

This block holds the configuration for a 12-input, 9-output crosspoint switch. A serial host interface that has already decoded its frames hands the block an 8-bit register address and an 8-bit data byte together with a single-cycle write strobe. The block keeps one routing register per output and a small set of per-input mode bits. From these it drives, for every output, the selected input index, a 2-bit gain code and an enable, and it drives a 12-bit clamp/bias mode vector for the inputs. The registers cannot be read back.

As a digital stand-in for the analog signal path, the block also carries 9 output lanes. Each lane is multiplexed from 12 input lanes according to its output's register. An enabled output with no valid input routed drives a fixed idle code. A disabled output raises a high-impedance flag and drives zero data. Turning an output off also clears its input selection, so switching it back on later does not bring back the old route.

Top module: `xpt_ctrl_bank`

## Requirements
- R1: After reset every output is disabled with gain code 0 and select code 0, every clamp mode bit is 0 (bias), every high-impedance flag is 1 and every output lane reads zero.
- R2: Output n (1 to 9) is configured at address 0x01+n-1. In the data byte, bit 7 is the enable, bits 6:5 are the gain code and bits 4:0 are the select code. With bit 7 set, the stored enable, gain and select equal the written fields.
- R3: A write to an output register with bit 7 clear stores select code 0 and enable 0, and keeps the written gain code.
- R4: An enabled output whose select code s is in 1..12 drives input lane s-1 on its output lane. Any number of outputs may select the same input.
- R5: An enabled output whose select code is 0, or any value from 13 to 31, drives the idle code (default 0x10) on its lane.
- R6: A disabled output has its high-impedance flag at 1 and its lane at zero. An enabled output has its flag at 0.
- R7: Address 0x1D sets clamp mode bits for inputs 1 to 8, with input k in data bit k-1. Address 0x1E sets inputs 9 to 12 from data bits 3:0. A bit value of 1 selects clamp and 0 selects bias.
- R8: Data bits 7:4 written to address 0x1E change nothing.
- R9: A write to any other address (0x00, 0x0A to 0x1C, 0x1F to 0xFF) changes no output of the block.
- R10: A write sampled on a clock edge is visible on the outputs right after that edge and not before it. Output lanes follow changes on the input lanes in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per register write |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 8 | Data byte of the write |
| in_lanes | input | N_IN*LANE_W (96) | Input lanes, input k at bits [(k-1)*8 +: 8] |
| out_sel | output | N_OUT*5 (45) | Stored select code per output, output n at [(n-1)*5 +: 5] |
| out_gain | output | N_OUT*2 (18) | Gain code per output, output n at [(n-1)*2 +: 2] |
| out_en | output | N_OUT (9) | Output enable, output n at bit n-1 |
| clamp_mode | output | N_IN (12) | Per-input mode, 1 = clamp, 0 = bias, input k at bit k-1 |
| out_lanes | output | N_OUT*LANE_W (72) | Output lanes, output n at [(n-1)*8 +: 8] |
| out_hiz | output | N_OUT (9) | High-impedance flag per output |

## Verification
Register results are due one clock edge after the strobe. The bench drives each write on a falling edge and samples on the next falling edge, after exactly one rising edge has captured it. One scenario also samples just after the drive edge to confirm that the old value still holds before the capturing edge. Output lanes are combinational from the stored setting and the input lanes, so an input lane change is checked one nanosecond after it is applied, within the same cycle.

// File: rtl/xpt_pkg.sv
// Package: shared types for the crosspoint control bank.
// Assumes one 8-bit register per output with enable, gain and select fields.
package xpt_pkg;
    localparam int unsigned SEL_W  = 5;
    localparam int unsigned GAIN_W = 2;

    // Stored configuration of one output
    typedef struct packed {
        logic              en;
        logic [GAIN_W-1:0] gain;
        logic [SEL_W-1:0]  sel;
    } out_cfg_t;
endpackage

// File: rtl/xpt_addr_decode.sv
// Module: xpt_addr_decode
// Turns a write strobe and address into one-hot write enables for the
// output registers and the clamp registers. Addresses that match nothing
// raise no enable. Assumes the base addresses keep the two ranges apart.
module xpt_addr_decode #(
    parameter int unsigned N_OUT      = 9,
    parameter int unsigned N_CLAMP    = 2,
    parameter int unsigned OUT_BASE   = 8'h01,
    parameter int unsigned CLAMP_BASE = 8'h1D
) (
    input  logic               wr_en,
    input  logic [7:0]         wr_addr,
    output logic [N_OUT-1:0]   out_we,
    output logic [N_CLAMP-1:0] clamp_we
);
    // One compare per output register
    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        assign out_we[j] = wr_en && (wr_addr == 8'(OUT_BASE + j));
    end

    // One compare per clamp register
    for (genvar c = 0; c < N_CLAMP; c++) begin : g_clamp
        assign clamp_we[c] = wr_en && (wr_addr == 8'(CLAMP_BASE + c));
    end
endmodule

// File: rtl/xpt_out_reg.sv
// Module: xpt_out_reg
// Holds the enable, gain and select of one output. A write with the enable
// bit clear also clears the select. Assumes the data byte has the enable in
// bit 7, the gain in bits 6:5 and the select in bits 4:0.
module xpt_out_reg
    import xpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output out_cfg_t   cfg
);
    // Capture the fields; turning the output off drops its route
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            cfg.en   <= wdata[7];
            cfg.gain <= wdata[6:5];
            cfg.sel  <= wdata[7] ? wdata[4:0] : '0;
        end
    end
endmodule

// File: rtl/xpt_clamp_reg.sv
// Module: xpt_clamp_reg
// Per-input clamp/bias mode bits, packed eight inputs per register. Bits of
// the last register above the input count are not stored, so writes to
// them are lost. Assumes clamp_we is one-hot or zero.
module xpt_clamp_reg #(
    parameter int unsigned N_IN    = 12,
    parameter int unsigned N_CLAMP = (N_IN + 7) / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CLAMP-1:0] clamp_we,
    input  logic [7:0]         wdata,
    output logic [N_IN-1:0]    clamp_mode
);
    for (genvar i = 0; i < N_IN; i++) begin : g_bit
        localparam int unsigned REG_IX = i / 8;
        localparam int unsigned BIT_IX = i % 8;
        // Load this input's mode bit from its register's write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                clamp_mode[i] <= 1'b0;
            end else if (clamp_we[REG_IX]) begin
                clamp_mode[i] <= wdata[BIT_IX];
            end
        end
    end
endmodule

// File: rtl/xpt_lane_mux.sv
// Module: xpt_lane_mux
// Digital model of one output path. Picks one input lane by select code,
// drives the idle code when no valid input is routed and drives zero with
// the high-impedance flag when the output is off. Purely combinational.
// Assumes N_IN is below 32 so that every input fits in the select code.
module xpt_lane_mux
    import xpt_pkg::*;
#(
    parameter int unsigned N_IN      = 12,
    parameter int unsigned LANE_W    = 8,
    parameter logic [LANE_W-1:0] IDLE_CODE = 8'h10
) (
    input  out_cfg_t                 cfg,
    input  logic [N_IN*LANE_W-1:0]   in_lanes,
    output logic [LANE_W-1:0]        lane_out,
    output logic                     hiz
);
    // Choose the lane value from enable and select code
    always_comb begin
        hiz      = !cfg.en;
        lane_out = '0;
        if (cfg.en) begin
            lane_out = IDLE_CODE;
            for (int k = 0; k < int'(N_IN); k++) begin
                if (cfg.sel == SEL_W'(k + 1)) begin
                    lane_out = in_lanes[k*LANE_W +: LANE_W];
                end
            end
        end
    end
endmodule

// File: rtl/xpt_ctrl_bank.sv
// Module: xpt_ctrl_bank (top)
// Register bank and output lane model of a crosspoint switch. One output
// register per output, packed clamp/bias bits per input, and a lane mux per
// output. Assumes one-cycle write strobes from an upstream serial decoder.
module xpt_ctrl_bank
    import xpt_pkg::*;
#(
    parameter int unsigned N_IN       = 12,
    parameter int unsigned N_OUT      = 9,
    parameter int unsigned LANE_W     = 8,
    parameter int unsigned OUT_BASE   = 8'h01,
    parameter int unsigned CLAMP_BASE = 8'h1D,
    parameter logic [LANE_W-1:0] IDLE_CODE = 8'h10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [7:0]                wr_addr,
    input  logic [7:0]                wr_data,
    input  logic [N_IN*LANE_W-1:0]    in_lanes,
    output logic [N_OUT*SEL_W-1:0]    out_sel,
    output logic [N_OUT*GAIN_W-1:0]   out_gain,
    output logic [N_OUT-1:0]          out_en,
    output logic [N_IN-1:0]           clamp_mode,
    output logic [N_OUT*LANE_W-1:0]   out_lanes,
    output logic [N_OUT-1:0]          out_hiz
);
    localparam int unsigned N_CLAMP = (N_IN + 7) / 8;

    logic [N_OUT-1:0]   out_we;
    logic [N_CLAMP-1:0] clamp_we;
    out_cfg_t           cfg [N_OUT];

    xpt_addr_decode #(
        .N_OUT      (N_OUT),
        .N_CLAMP    (N_CLAMP),
        .OUT_BASE   (OUT_BASE),
        .CLAMP_BASE (CLAMP_BASE)
    ) u_dec (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .out_we   (out_we),
        .clamp_we (clamp_we)
    );

    xpt_clamp_reg #(
        .N_IN    (N_IN),
        .N_CLAMP (N_CLAMP)
    ) u_clamp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clamp_we   (clamp_we),
        .wdata      (wr_data),
        .clamp_mode (clamp_mode)
    );

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        xpt_out_reg u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (out_we[j]),
            .wdata (wr_data),
            .cfg   (cfg[j])
        );

        xpt_lane_mux #(
            .N_IN      (N_IN),
            .LANE_W    (LANE_W),
            .IDLE_CODE (IDLE_CODE)
        ) u_mux (
            .cfg      (cfg[j]),
            .in_lanes (in_lanes),
            .lane_out (out_lanes[j*LANE_W +: LANE_W]),
            .hiz      (out_hiz[j])
        );

        // Flatten the stored fields onto the control ports
        assign out_sel[j*SEL_W +: SEL_W]    = cfg[j].sel;
        assign out_gain[j*GAIN_W +: GAIN_W] = cfg[j].gain;
        assign out_en[j]                    = cfg[j].en;
    end
endmodule

// File: rtl/xpt_ctrl_chk.sv
// Module: xpt_ctrl_chk
// Property checker for xpt_ctrl_bank, attached by the bind below. Relates
// write strobes to the control ports one edge later and the lane outputs
// to the enables.
module xpt_ctrl_chk #(
    parameter int unsigned N_IN       = 12,
    parameter int unsigned N_OUT      = 9,
    parameter int unsigned LANE_W     = 8,
    parameter int unsigned OUT_BASE   = 8'h01,
    parameter int unsigned CLAMP_BASE = 8'h1D
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [7:0]                wr_addr,
    input logic [7:0]                wr_data,
    input logic [N_OUT*5-1:0]        out_sel,
    input logic [N_OUT*2-1:0]        out_gain,
    input logic [N_OUT-1:0]          out_en,
    input logic [N_IN-1:0]           clamp_mode,
    input logic [N_OUT*LANE_W-1:0]   out_lanes,
    input logic [N_OUT-1:0]          out_hiz
);
    localparam int unsigned N_CLAMP = (N_IN + 7) / 8;

    logic is_mapped;
    // Address falls in either register range
    always_comb begin
        is_mapped = ((wr_addr >= 8'(OUT_BASE)) && (wr_addr < 8'(OUT_BASE + N_OUT)))
                 || ((wr_addr >= 8'(CLAMP_BASE)) && (wr_addr < 8'(CLAMP_BASE + N_CLAMP)));
    end

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        // R2
        on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == 8'(OUT_BASE + j) && wr_data[7]) |=>
            (out_en[j] && out_sel[j*5 +: 5] == $past(wr_data[4:0])
                       && out_gain[j*2 +: 2] == $past(wr_data[6:5])));
        // R3
        off_clears_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == 8'(OUT_BASE + j) && !wr_data[7]) |=>
            (!out_en[j] && out_sel[j*5 +: 5] == 5'd0));
        // R6
        off_lane_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_hiz[j] == !out_en[j])
            && (out_en[j] || out_lanes[j*LANE_W +: LANE_W] == '0));
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        // R7
        clamp_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == 8'(CLAMP_BASE + i / 8)) |=>
            (clamp_mode[i] == $past(wr_data[i % 8])));
    end

    // R9
    unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !is_mapped) |=>
        ($stable(out_sel) && $stable(out_gain) && $stable(out_en)
                          && $stable(clamp_mode) && $stable(out_hiz)));
endmodule

bind xpt_ctrl_bank xpt_ctrl_chk #(
    .N_IN       (N_IN),
    .N_OUT      (N_OUT),
    .LANE_W     (LANE_W),
    .OUT_BASE   (OUT_BASE),
    .CLAMP_BASE (CLAMP_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .out_sel    (out_sel),
    .out_gain   (out_gain),
    .out_en     (out_en),
    .clamp_mode (clamp_mode),
    .out_lanes  (out_lanes),
    .out_hiz    (out_hiz)
);

// File: tb/tb_xpt_ctrl_bank.sv
// Directed bench for xpt_ctrl_bank: one task per scenario.
module tb_xpt_ctrl_bank;
    localparam int NI = 12;
    localparam int NO = 9;
    localparam logic [7:0] IDLE = 8'h10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [NI*8-1:0] in_lanes;
    logic [NO*5-1:0] out_sel;
    logic [NO*2-1:0] out_gain;
    logic [NO-1:0]   out_en;
    logic [NI-1:0]   clamp_mode;
    logic [NO*8-1:0] out_lanes;
    logic [NO-1:0]   out_hiz;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    xpt_ctrl_bank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .in_lanes(in_lanes), .out_sel(out_sel),
        .out_gain(out_gain), .out_en(out_en), .clamp_mode(clamp_mode),
        .out_lanes(out_lanes), .out_hiz(out_hiz)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One register write; returns on the falling edge after capture
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] lane(input int n);
        return out_lanes[(n-1)*8 +: 8];
    endfunction

    task automatic t_reset();
        chk("R1 en", 32'(out_en), 0);
        chk("R1 sel", 32'(out_sel[31:0]), 0);
        chk("R1 gain", 32'(out_gain), 0);
        chk("R1 clamp", 32'(clamp_mode), 0);
        chk("R1 hiz", 32'(out_hiz), 32'h1FF);
        chk("R1 lanes", 32'(out_lanes[31:0]), 0);
    endtask

    task automatic t_route();
        wr(8'h01, 8'b1_10_00011);
        chk("R2 en1", 32'(out_en[0]), 1);
        chk("R2 gain1", 32'(out_gain[1:0]), 2);
        chk("R2 sel1", 32'(out_sel[4:0]), 3);
        chk("R4 lane1", 32'(lane(1)), 32'hA2);
        chk("R6 hiz1", 32'(out_hiz[0]), 0);
        wr(8'h09, 8'b1_11_01100);
        chk("R4 lane9", 32'(lane(9)), 32'hAB);
        chk("R2 gain9", 32'(out_gain[17:16]), 3);
        wr(8'h05, 8'b1_01_00011);
        chk("R4 shared lane5", 32'(lane(5)), 32'hA2);
        chk("R4 shared lane1", 32'(lane(1)), 32'hA2);
        // R10: lanes follow inputs in the same cycle
        @(negedge clk);
        in_lanes[2*8 +: 8] = 8'h5C;
        #1;
        chk("R10 lane1 follows", 32'(lane(1)), 32'h5C);
        chk("R10 lane5 follows", 32'(lane(5)), 32'h5C);
        in_lanes[2*8 +: 8] = 8'hA2;
    endtask

    task automatic t_timing();
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h06; wr_data = 8'b1_11_00111;
        #1;
        chk("R10 not before edge", 32'(out_en[5]), 0);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R10 after edge", 32'(out_en[5]), 1);
        chk("R4 lane6", 32'(lane(6)), 32'hA6);
    endtask

    task automatic t_idle();
        wr(8'h02, 8'b1_00_00000);
        chk("R5 sel0 idle", 32'(lane(2)), 32'(IDLE));
        wr(8'h03, 8'b1_01_01101);
        chk("R5 sel13 idle", 32'(lane(3)), 32'(IDLE));
        chk("R2 sel13 stored", 32'(out_sel[14:10]), 13);
        wr(8'h04, 8'b1_00_11111);
        chk("R5 sel31 idle", 32'(lane(4)), 32'(IDLE));
        chk("R6 idle not hiz", 32'(out_hiz[3]), 0);
    endtask

    task automatic t_disable();
        wr(8'h01, 8'b0_11_00101);
        chk("R3 en off", 32'(out_en[0]), 0);
        chk("R3 sel cleared", 32'(out_sel[4:0]), 0);
        chk("R3 gain kept", 32'(out_gain[1:0]), 3);
        chk("R6 hiz on", 32'(out_hiz[0]), 1);
        chk("R6 lane zero", 32'(lane(1)), 0);
        chk("R4 lane5 unaffected", 32'(lane(5)), 32'hA2);
        wr(8'h01, 8'b1_11_00000);
        chk("R3 reenable no old route", 32'(lane(1)), 32'(IDLE));
    endtask

    task automatic t_clamp();
        wr(8'h1D, 8'h81);
        chk("R7 low reg", 32'(clamp_mode), 32'h081);
        wr(8'h1E, 8'hF5);
        chk("R7 R8 high reg", 32'(clamp_mode), 32'h581);
        wr(8'h1E, 8'hF0);
        chk("R8 reserved bits", 32'(clamp_mode), 32'h081);
    endtask

    task automatic t_unmapped();
        logic [NO*5+NO*2+NO+NI+NO*8+NO-1:0] snap;
        logic [7:0] addrs [5] = '{8'h00, 8'h0A, 8'h1C, 8'h1F, 8'hFF};
        snap = {out_sel, out_gain, out_en, clamp_mode, out_lanes, out_hiz};
        for (int k = 0; k < 5; k++) begin
            wr(addrs[k], 8'hFF);
            chk($sformatf("R9 addr %02h", addrs[k]),
                32'({out_sel, out_gain, out_en, clamp_mode, out_lanes, out_hiz} == snap), 1);
        end
    endtask

    initial begin
        for (int i = 0; i < NI; i++) in_lanes[i*8 +: 8] = 8'hA0 + 8'(i);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_route();
        t_timing();
        t_idle();
        t_disable();
        t_clamp();
        t_unmapped();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule